// File: doc/BRIEF.md
# Looping Dock Instruction Queue

This block steers the instruction path of one dock. Instruction words are offered at an input stage, pass an admission gate into a circular FIFO, and move one at a time into a single on-deck slot. While an instruction sits on deck, two activities run side by side. The first decides whether a copy of the instruction goes back into the FIFO as part of a multi-instruction outer loop. The second either runs the instruction through the execution datapath or skips it. The slot is freed only when both activities have finished.

Two control words never enter the FIFO. A seal word closes the admission gate, so that only recirculated copies can enter the FIFO. An abort word cuts short the execution of an unprotected on-deck instruction. The execution datapath is driven through a start pulse and answers with a done pulse. The outer loop counter, kept outside this block, reports only whether it is zero. The block asks for the counter to be forced to zero, and for the inner counter to be cleared, through single-cycle outputs.

Top module: `dock_loop_queue`

## Requirements
- R1: After reset the gate is unsealed, the FIFO is empty (`fifo_empty`=1) and the on-deck slot is free (`deck_valid`=0).
- R2: A word is decoded from its top four bits: bit IW-1 is the protect bit, bit IW-2 is the outer-loop bit, and bits IW-3:IW-4 give the kind (00 plain, 01 set-outer, 10 seal, 11 abort). A seal word is always accepted. It sets `sealed` on the next cycle, never enters the FIFO and never reaches the deck. If a seal is accepted in the same cycle as a skip, the seal wins.
- R3: A plain or set-outer word is accepted only while the gate is unsealed and the FIFO is not full. Otherwise `in_ready` stays low and the word waits. `fifo_full` rises once DEPTH words are stored. Words leave the FIFO in the order they entered.
- R4: The outer-loop bit and `oc_zero` are sampled in the cycle an instruction moves onto the deck. If the bit is set and the counter is nonzero, a copy of the instruction is pushed at the FIFO tail once the gate is sealed and the FIFO has room.
- R5: If `oc_zero` is high when an instruction moves onto the deck, and the instruction is not a set-outer word with its outer-loop bit clear, it is skipped. No `ex_start` is issued, `clr_inner` pulses once and the gate is unsealed.
- R6: An abort word is accepted only while the deck holds an instruction whose protect bit is clear. Until then it waits at the input, whatever the gate state.
- R7: An accepted abort pulses `abort_hit` and ends any pending execution attempt of the on-deck instruction without waiting for `ex_done`. If the abort arrives in the cycle the attempt would start, `ex_start` is not issued.
- R8: An executed instruction issues exactly one `ex_start` and completes on `ex_done`. The deck retires (a `retire` pulse, with `deck_data` valid) only after execution and any pending copy have both completed, including when the instruction was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input stage holds a word |
| in_data | input | IW | Instruction word at input stage |
| in_ready | output | 1 | Input word is consumed this cycle |
| oc_zero | input | 1 | Outer loop counter is zero |
| ex_done | input | 1 | Execution datapath finished the attempt |
| ex_start | output | 1 | Start an execution attempt of the on-deck word |
| clr_inner | output | 1 | Clear the inner loop counter |
| abort_hit | output | 1 | Abort accepted; force outer counter to zero |
| sealed | output | 1 | Admission gate is sealed |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |
| deck_valid | output | 1 | On-deck slot occupied |
| deck_data | output | IW | On-deck instruction word |
| retire | output | 1 | On-deck instruction leaves the deck this cycle |

## Verification
The hardest state to reach is an outer loop that spins and then winds down. To get there, two looping words are admitted while the gate is open and the gate is sealed behind them. The bench lets the copies circulate for several rounds, then raises `oc_zero` at a known retirement, so that exactly the copies already queued are skipped and the gate reopens. The abort race is set up by offering the abort immediately behind a fresh instruction. It is therefore accepted in the cycle the attempt would start. The execution responder can be switched off, which parks an instruction in its wait state, so that the abort, protect and full-FIFO stalls can be held open and observed.

// File: rtl/dock_loop_queue.sv
module dock_loop_queue #(
  parameter int IW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_data,
  output logic          in_ready,
  input  logic          oc_zero,
  input  logic          ex_done,
  output logic          ex_start,
  output logic          clr_inner,
  output logic          abort_hit,
  output logic          sealed,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          deck_valid,
  output logic [IW-1:0] deck_data,
  output logic          retire
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PROT = IW - 1;
  localparam int OLB  = IW - 2;
  localparam logic [1:0] K_SETOC = 2'b01, K_SEAL = 2'b10, K_ABORT = 2'b11;

  typedef enum logic [1:0] {X_IDLE, X_SKIP, X_GO, X_WAIT} xstate_t;

  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          rc_pend;
  xstate_t       xs;

  wire [1:0]    in_kind    = in_data[IW-3:IW-4];
  wire [IW-1:0] head       = mem[rp];
  wire [1:0]    head_kind  = head[IW-3:IW-4];
  wire          abort_ok   = deck_valid & ~deck_data[PROT];
  wire          seal_take  = in_valid & (in_kind == K_SEAL);
  wire          abort_take = in_valid & (in_kind == K_ABORT) & abort_ok;
  wire          push_in    = in_valid & ~in_kind[1] & ~sealed & ~fifo_full;
  wire          push_rc    = rc_pend & sealed & ~fifo_full;
  wire          push       = push_in | push_rc;
  wire [IW-1:0] push_d     = push_rc ? deck_data : in_data;
  wire          pop        = ~deck_valid & ~fifo_empty;
  wire          head_skip  = oc_zero & ~(head_kind == K_SETOC & ~head[OLB]);

  assign fifo_full  = (cnt == CW'(DEPTH));
  assign fifo_empty = (cnt == '0);
  assign in_ready   = (in_kind == K_SEAL)  ? 1'b1 :
                      (in_kind == K_ABORT) ? abort_ok :
                      (~sealed & ~fifo_full);
  assign ex_start   = (xs == X_GO) & ~abort_take;
  assign clr_inner  = (xs == X_SKIP);
  assign abort_hit  = abort_take;
  assign retire     = deck_valid & ~rc_pend & (xs == X_IDLE);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sealed <= 1'b0;
    end else if (seal_take) begin
      sealed <= 1'b1;
    end else if (xs == X_SKIP) begin
      sealed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deck_valid <= 1'b0;
      deck_data  <= '0;
      rc_pend    <= 1'b0;
      xs         <= X_IDLE;
    end else if (pop) begin
      deck_valid <= 1'b1;
      deck_data  <= head;
      rc_pend    <= head[OLB] & ~oc_zero;
      xs         <= head_skip ? X_SKIP : X_GO;
    end else if (retire) begin
      deck_valid <= 1'b0;
    end else begin
      if (push_rc) rc_pend <= 1'b0;
      case (xs)
        X_SKIP:  xs <= X_IDLE;
        X_GO:    xs <= abort_take ? X_IDLE : X_WAIT;
        X_WAIT:  if (abort_take || ex_done) xs <= X_IDLE;
        default: xs <= X_IDLE;
      endcase
    end
  end

  a_r7_abort_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |-> !ex_start);
  a_r5_skip_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr_inner |-> !ex_start);
  a_r2_seal_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == K_SEAL) |=> sealed);
  a_r3_sealed_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && in_valid && !in_kind[1]) |-> !in_ready);
  a_r6_abort_needs_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |-> (deck_valid && !deck_data[PROT]));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !$rose(fifo_empty) && (cnt <= CW'(DEPTH)));
  a_r8_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    ex_start |=> !ex_start);
endmodule

// File: tb/dock_loop_queue_bench.sv
module dock_loop_queue_bench;
  localparam int IW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, oc_zero = 1'b0, ex_done;
  logic [IW-1:0] in_data = '0;
  logic in_ready, ex_start, clr_inner, abort_hit, sealed, fifo_full, fifo_empty;
  logic deck_valid, retire;
  logic [IW-1:0] deck_data;

  dock_loop_queue #(.IW(IW), .DEPTH(DEPTH)) u_dock_loop_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .oc_zero(oc_zero), .ex_done(ex_done),
    .ex_start(ex_start), .clr_inner(clr_inner), .abort_hit(abort_hit),
    .sealed(sealed), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .deck_valid(deck_valid), .deck_data(deck_data), .retire(retire));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int n_start = 0, n_clr = 0, n_abort = 0, n_ret = 0;
  logic auto_en = 1'b1, man_done = 1'b0, pend = 1'b0;
  logic [IW-1:0] sb[$];

  function automatic logic [IW-1:0] mk(logic p, logic ol, logic [1:0] k, logic [11:0] pl);
    return {p, ol, k, pl};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ret(input logic [IW-1:0] w);
    sb.push_back(w);
  endtask

  task automatic send(input logic [IW-1:0] w);
    @(negedge clk); in_data = w; in_valid = 1'b1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 man_done = 1'b1;
    @(posedge clk); #1 man_done = 1'b0;
  endtask

  initial begin
    ex_done = 1'b0;
    forever begin
      @(negedge clk);
      ex_done = (auto_en && pend) || man_done;
      pend = ex_start;
    end
  end

  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (ex_start) n_start++;
        if (clr_inner) n_clr++;
        if (abort_hit) n_abort++;
        if (retire) begin
          n_ret++;
          if (sb.size() == 0) chk(0, "R8 unexpected retire", int'(deck_data), -1);
          else begin
            logic [IW-1:0] e;
            e = sb.pop_front();
            chk(deck_data == e, "R8 retire order", int'(deck_data), int'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [IW-1:0] wa, wb, wx, wy, wz, ww, wg, wab;
    int s0, c0, a0;
    wab = mk(0, 0, 2'b11, 12'h0);
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    idle(1);
    chk(!sealed && fifo_empty && !deck_valid, "R1 reset state", {sealed, fifo_empty, deck_valid}, 3'b010);

    send(mk(0, 0, 2'b10, 12'h0));
    idle(3);
    chk(sealed == 1'b1, "R2 seal sets gate", sealed, 1);
    chk(fifo_empty && !deck_valid, "R2 seal not enqueued", {fifo_empty, deck_valid}, 2'b10);
    @(negedge clk) rst_n = 1'b0; @(negedge clk) rst_n = 1'b1; #1;
    chk(!sealed, "R1 reset unseals", sealed, 0);

    s0 = n_start;
    for (int i = 0; i < 3; i++) begin
      expect_ret(mk(0, 0, 2'b00, 12'h10 + 12'(i)));
      send(mk(0, 0, 2'b00, 12'h10 + 12'(i)));
    end
    idle(12);
    chk(n_start - s0 == 3, "R8 one start each", n_start - s0, 3);

    wa = mk(0, 1, 2'b00, 12'hA1); wb = mk(0, 1, 2'b00, 12'hB2);
    for (int i = 0; i < 4; i++) begin expect_ret(wa); expect_ret(wb); end
    s0 = n_start; c0 = n_clr; n_ret = 0;
    send(wa); send(wb); send(mk(0, 0, 2'b10, 12'h0));
    @(negedge clk); in_data = mk(0, 0, 2'b00, 12'hCC); in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!in_ready, "R3 sealed gate blocks entry", in_ready, 0);
    end
    in_valid = 1'b0;
    wait (n_ret == 6);
    @(negedge clk) oc_zero = 1'b1;
    idle(12);
    chk(n_start - s0 == 6, "R4 loop executions", n_start - s0, 6);
    chk(n_clr - c0 == 2, "R5 skipped copies", n_clr - c0, 2);
    chk(!sealed && fifo_empty, "R5 skip unseals gate", {sealed, fifo_empty}, 2'b01);

    s0 = n_start; c0 = n_clr;
    expect_ret(mk(0, 0, 2'b01, 12'h33)); send(mk(0, 0, 2'b01, 12'h33));
    idle(8);
    chk(n_start - s0 == 1 && n_clr == c0, "R5 set-outer runs at zero", n_start - s0, 1);
    expect_ret(mk(0, 0, 2'b00, 12'h44)); send(mk(0, 0, 2'b00, 12'h44));
    expect_ret(mk(0, 1, 2'b01, 12'h55)); send(mk(0, 1, 2'b01, 12'h55));
    idle(8);
    chk(n_start - s0 == 1 && n_clr - c0 == 2, "R5 skip at zero", n_clr - c0, 2);

    oc_zero = 1'b0; auto_en = 1'b0;
    wx = mk(0, 0, 2'b00, 12'h77);
    expect_ret(wx); send(wx);
    idle(5);
    chk(deck_valid && sb.size() == 1, "R7 parked attempt", sb.size(), 1);
    a0 = n_abort;
    send(wab);
    idle(3);
    chk(n_abort - a0 == 1 && sb.size() == 0, "R7 abort retires", n_abort - a0, 1);

    wy = mk(1, 0, 2'b00, 12'h88);
    expect_ret(wy); send(wy);
    idle(3);
    @(negedge clk); in_data = wab; in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!in_ready, "R6 protected ignores abort", in_ready, 0);
    end
    in_valid = 1'b0;
    pulse_done();
    idle(3);
    chk(sb.size() == 0 && !deck_valid, "R8 protected completes", sb.size(), 0);
    @(negedge clk); in_data = wab; in_valid = 1'b1; #1;
    chk(!in_ready, "R6 abort waits on empty deck", in_ready, 0);
    @(negedge clk) in_valid = 1'b0;

    s0 = n_start; a0 = n_abort; c0 = n_clr;
    wz = mk(0, 1, 2'b00, 12'h99);
    expect_ret(wz); expect_ret(wz);
    send(wz); send(wab);
    oc_zero = 1'b1;
    idle(3);
    chk(n_start == s0 && n_abort - a0 == 1, "R7 abort beats start", n_start - s0, 0);
    chk(deck_valid && sb.size() == 2, "R8 deck held for copy", sb.size(), 2);
    send(mk(0, 0, 2'b10, 12'h0));
    idle(8);
    chk(sb.size() == 0 && n_clr - c0 == 1 && !sealed, "R4 aborted copy recirculates", sb.size(), 0);

    oc_zero = 1'b0;
    ww = mk(0, 0, 2'b00, 12'h100);
    expect_ret(ww); send(ww);
    for (int i = 0; i < DEPTH; i++) begin
      expect_ret(mk(0, 0, 2'b00, 12'h200 + 12'(i)));
      send(mk(0, 0, 2'b00, 12'h200 + 12'(i)));
    end
    idle(1);
    chk(fifo_full, "R3 full at depth", fifo_full, 1);
    wg = mk(0, 0, 2'b00, 12'h300);
    @(negedge clk); in_data = wg; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!in_ready, "R3 full stalls entry", in_ready, 0);
    end
    in_valid = 1'b0;
    auto_en = 1'b1;
    pulse_done();
    idle(20);
    expect_ret(wg); send(wg);
    idle(8);
    chk(sb.size() == 0 && fifo_empty, "R3 fifo order drained", sb.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule